// File: doc/BRIEF.md
# Phase-Accumulator Sine Synthesizer

This block is a direct digital synthesis core. Each clock it adds a 24-bit frequency tuning word to a phase accumulator, adds a programmable phase offset, and turns the top bits of that phase into a 14-bit two's-complement sine sample through a quarter-wave lookup table. The table is computed from constants when the design is elaborated. The output frequency is the clock rate times the tuning word divided by 2^24, so one tuning-word step is one 2^24-th of the clock rate.

A configuration port writes shadow registers. These are the upper and lower parts of the tuning word, the phase offset, a cycle count and a mode field. Nothing written there affects the waveform until an update strobe commits every shadow register to its working copy at the same time. The commit also restarts the accumulator from zero and reloads the period counter. In counted mode the core emits the programmed number of whole output periods and then falls silent until the next commit. When the core is not enabled or has finished its periods, the output holds at zero and the valid flag is low.

Top module: `dds_sine_core`

## Requirements
- R1: A synchronous reset clears the accumulator, every shadow and working register and the period counter. Right after reset the output is zero with valid low. Enabling the core with nothing loaded gives valid samples of the table value at phase address 0 (about +6).
- R2: A write to address 0 places data bits [15:0] in tuning-word bits [23:8]. A write to address 1 places data bits [15:8] in tuning-word bits [7:0], and its data bits [7:0] are ignored.
- R3: Writes to the shadow registers do not change the accumulator, the offset or the output until the update strobe. An update and a write in the same cycle commit the value the shadow held before that write.
- R4: The update strobe copies all shadow registers to the working registers, clears the accumulator to zero and loads the period counter from the cycle-count register (address 3).
- R5: In each enabled, running cycle the accumulator advances by the tuning word modulo 2^24. The sample registered at clock edge n+1 comes from the accumulator value held between edges n and n+1, and valid is high with it.
- R6: The phase-offset register (address 2, 16 bits) is added to accumulator bits [23:8] before the lookup. The lookup address is bits [23:12] of that sum.
- R7: For lookup address a, the sample is within 1 LSB of round(8191 * sin(2*pi*(a+0.5)/4096)). It never takes the value -8192.
- R8: While the enable input is low, the accumulator holds its value, the sample is zero and valid is low.
- R9: The mode register (address 4, bits [1:0]) selects counted operation when it equals 2. In that mode the output stops (zero, valid low) after the cycle count of accumulator wraps, until the next update. Any other mode value runs without a limit.
- R10: In counted mode a cycle count of zero gives no valid output at all.
- R11: Writes to addresses 5, 6 and 7 have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Shadow register write enable |
| cfg_addr | input | 3 | Shadow register address |
| cfg_wdata | input | 16 | Shadow register write data |
| update_i | input | 1 | Commit shadow registers to working copies and restart |
| en_i | input | 1 | Run enable |
| sample_o | output | 14 | Signed sine sample |
| valid_o | output | 1 | Sample is live |

## Verification
A zero tuning word with several phase offsets holds single table points and isolates the offset path and the quadrant mirroring. Tuning words of 1/16 and 1/4 of a cycle sweep all four quadrants. An odd word that has garbage in the ignored low byte of its second register shows whether the two registers are assembled correctly. A near-full-scale word checks the modulo wrap. Counted runs with counts of 3, 0 and a non-counting mode value tell the stop point apart from an off-by-one stop and from a mode decode error. Writes that are not committed, writes to unused addresses and enable gaps each leave the expected sample stream unchanged, so a leak shows up in the compared output.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam int CFG_AW = 3;

   typedef enum logic [CFG_AW-1:0] {
      SEL_TUNE_HI = 3'd0,
      SEL_TUNE_LO = 3'd1,
      SEL_PHASE   = 3'd2,
      SEL_CYCLES  = 3'd3,
      SEL_MODE    = 3'd4
   } cfg_sel_e;

   localparam logic [1:0] MODE_COUNTED = 2'd2;
endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs #(
   parameter int ACC_W = 24,
   parameter int REG_W = 16,
   parameter int CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr,
   input  logic [dds_pkg::CFG_AW-1:0] addr,
   input  logic [REG_W-1:0]           wdata,
   input  logic                       upd,
   output logic [ACC_W-1:0]           tune_act,
   output logic [REG_W-1:0]           phase_act,
   output logic                       counted_act,
   output logic [CNT_W-1:0]           cycles_sh
);
   import dds_pkg::*;
   localparam int LO_W = ACC_W - REG_W;

   logic [REG_W-1:0] hi_sh, phase_sh;
   logic [LO_W-1:0]  lo_sh;
   logic [1:0]       mode_sh;
   logic [CNT_W-1:0] cyc_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_sh       <= '0;
         lo_sh       <= '0;
         phase_sh    <= '0;
         mode_sh     <= '0;
         cyc_sh      <= '0;
         tune_act    <= '0;
         phase_act   <= '0;
         counted_act <= 1'b0;
      end else begin
         if (upd) begin
            tune_act    <= {hi_sh, lo_sh};
            phase_act   <= phase_sh;
            counted_act <= (mode_sh == MODE_COUNTED);
         end
         if (wr) begin
            case (cfg_sel_e'(addr))
               SEL_TUNE_HI: hi_sh    <= wdata;
               SEL_TUNE_LO: lo_sh    <= wdata[REG_W-1 -: LO_W];
               SEL_PHASE:   phase_sh <= wdata;
               SEL_CYCLES:  cyc_sh   <= wdata[CNT_W-1:0];
               SEL_MODE:    mode_sh  <= wdata[1:0];
               default: ;
            endcase
         end
      end
   end

   assign cycles_sh = cyc_sh;
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 24,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             upd,
   input  logic [ACC_W-1:0] tune,
   input  logic             counted,
   input  logic [CNT_W-1:0] cycles_load,
   output logic [ACC_W-1:0] acc,
   output logic             halted,
   output logic             active
);
   logic [ACC_W:0]   sum;
   logic [CNT_W-1:0] left_q;

   assign sum    = {1'b0, acc} + {1'b0, tune};
   assign halted = counted && (left_q == '0);
   assign active = en && !halted;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc    <= '0;
         left_q <= '0;
      end else if (upd) begin
         acc    <= '0;
         left_q <= cycles_load;
      end else if (active) begin
         acc <= sum[ACC_W-1:0];
         if (counted && sum[ACC_W])
            left_q <= left_q - 1'b1;
      end
   end
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
   parameter int LUT_AW     = 12,
   parameter int OUT_W      = 14,
   parameter bit FULL_TABLE = 1'b0
) (
   input  logic [LUT_AW-1:0]       addr,
   output logic signed [OUT_W-1:0] sample
);
   localparam int  FULL_N = 1 << LUT_AW;
   localparam int  QTR_W  = LUT_AW - 2;
   localparam int  QTR_N  = 1 << QTR_W;
   localparam real AMP    = real'((1 << (OUT_W-1)) - 1);
   localparam real TWO_PI = 6.283185307179586;

   generate
      if (FULL_TABLE) begin : g_full
         logic [OUT_W-1:0] rom [FULL_N];
         for (genvar k = 0; k < FULL_N; k++) begin : g_ent
            localparam real X = AMP * $sin(TWO_PI * (real'(k) + 0.5) / real'(FULL_N));
            localparam int  V = (X >= 0.0) ? $rtoi(X + 0.5) : -$rtoi(0.5 - X);
            assign rom[k] = V[OUT_W-1:0];
         end
         assign sample = $signed(rom[addr]);
      end else begin : g_quarter
         logic [OUT_W-2:0] rom [QTR_N];
         logic [QTR_W-1:0] idx;
         logic [OUT_W-2:0] mag;
         for (genvar k = 0; k < QTR_N; k++) begin : g_ent
            localparam int V = $rtoi(AMP * $sin(TWO_PI * (real'(k) + 0.5) / real'(FULL_N)) + 0.5);
            assign rom[k] = V[OUT_W-2:0];
         end
         assign idx    = addr[LUT_AW-2] ? ~addr[QTR_W-1:0] : addr[QTR_W-1:0];
         assign mag    = rom[idx];
         assign sample = addr[LUT_AW-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
      end
   endgenerate
endmodule

// File: rtl/dds_sine_core.sv
module dds_sine_core #(
   parameter int ACC_W      = 24,
   parameter int OUT_W      = 14,
   parameter int REG_W      = 16,
   parameter int LUT_AW     = 12,
   parameter int CNT_W      = 16,
   parameter bit FULL_TABLE = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cfg_wr,
   input  logic [dds_pkg::CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]           cfg_wdata,
   input  logic                       update_i,
   input  logic                       en_i,
   output logic [OUT_W-1:0]           sample_o,
   output logic                       valid_o
);
   localparam int PH_SH = ACC_W - REG_W;

   generate
      if (ACC_W <= REG_W || ACC_W > 2*REG_W) begin : g_bad_split
         $error("tuning word must span two registers");
      end
      if (LUT_AW < 3 || LUT_AW > ACC_W) begin : g_bad_lut
         $error("lookup address width out of range");
      end
      if (CNT_W > REG_W) begin : g_bad_cnt
         $error("cycle count wider than a register");
      end
   endgenerate

   logic [ACC_W-1:0]        tune_act, acc, phase_sum;
   logic [REG_W-1:0]        phase_act;
   logic                    counted_act, halted, active;
   logic [CNT_W-1:0]        cycles_sh;
   logic signed [OUT_W-1:0] lut_out;

   dds_cfg_regs #(.ACC_W(ACC_W), .REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst(rst), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
      .upd(update_i), .tune_act(tune_act), .phase_act(phase_act),
      .counted_act(counted_act), .cycles_sh(cycles_sh)
   );

   dds_phase_acc #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
      .clk(clk), .rst(rst), .en(en_i), .upd(update_i), .tune(tune_act),
      .counted(counted_act), .cycles_load(cycles_sh), .acc(acc),
      .halted(halted), .active(active)
   );

   assign phase_sum = acc + {phase_act, {PH_SH{1'b0}}};

   dds_sine_lut #(.LUT_AW(LUT_AW), .OUT_W(OUT_W), .FULL_TABLE(FULL_TABLE)) u_lut (
      .addr(phase_sum[ACC_W-1 -: LUT_AW]), .sample(lut_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         sample_o <= active ? lut_out : '0;
         valid_o  <= active;
      end
   end
endmodule

// File: rtl/dds_sine_chk.sv
module dds_sine_chk #(
   parameter int ACC_W = 24,
   parameter int OUT_W = 14
) (
   input logic             clk,
   input logic             rst,
   input logic             upd,
   input logic             en,
   input logic             active,
   input logic             halted,
   input logic [ACC_W-1:0] acc,
   input logic [ACC_W-1:0] tune_act,
   input logic [OUT_W-1:0] sample_o,
   input logic             valid_o
);
   localparam logic [OUT_W-1:0] NEG_FULL = {1'b1, {(OUT_W-1){1'b0}}};

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid_o && sample_o == '0)); // R1
   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      !upd |=> $stable(tune_act)); // R3
   AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (rst)
      upd |=> (acc == '0)); // R4
   AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (active && !upd) |=> (acc == ACC_W'($past(acc) + $past(tune_act)))); // R5
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      active |=> valid_o); // R5
   AST_NO_NEG_FULL: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (sample_o != NEG_FULL)); // R7
   AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!en && !upd) |=> ($stable(acc) && !valid_o && sample_o == '0)); // R8
   AST_HALT_SILENT: assert property (@(posedge clk) disable iff (rst)
      (halted && !upd) |=> (!valid_o && sample_o == '0)); // R9
endmodule

bind dds_sine_core dds_sine_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
   .clk(clk), .rst(rst), .upd(update_i), .en(en_i), .active(active),
   .halted(halted), .acc(acc), .tune_act(tune_act),
   .sample_o(sample_o), .valid_o(valid_o)
);

// File: tb/dds_sine_core_test.sv
module dds_sine_core_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        update_i = 1'b0;
   logic        en_i = 1'b0;
   logic [13:0] sample_o;
   logic        valid_o;

   always #10 clk = ~clk;

   dds_sine_core uut (
      .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .update_i(update_i), .en_i(en_i),
      .sample_o(sample_o), .valid_o(valid_o)
   );

   typedef struct {
      logic  valid;
      int    value;
      string req;
   } exp_t;

   exp_t  sb[$];
   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string req_tag = "R1";

   // reference model state (requirement level)
   logic [15:0] m_hi, m_ph, m_cyc;
   logic [7:0]  m_lo;
   logic [1:0]  m_mode;
   logic [23:0] m_tune, m_acc;
   logic [15:0] m_phase, m_left;
   logic        m_counted;

   function automatic int ref_sine(input int a);
      real x;
      x = 8191.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 4096.0);
      return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
   endfunction

   task automatic model_reset();
      m_hi = '0; m_ph = '0; m_cyc = '0; m_lo = '0; m_mode = '0;
      m_tune = '0; m_acc = '0; m_phase = '0; m_left = '0; m_counted = 1'b0;
   endtask

   // driver: apply one cycle of stimulus and push the expected result
   task automatic cyc(input logic wr, input logic [2:0] a, input logic [15:0] d,
                      input logic upd, input logic en);
      exp_t        e;
      logic        act;
      logic [23:0] ph;
      logic [24:0] s;
      cfg_wr = wr; cfg_addr = a; cfg_wdata = d; update_i = upd; en_i = en;
      act = en && !(m_counted && m_left == 0);
      ph  = m_acc + {m_phase, 8'h00};
      e.valid = act;
      e.value = act ? ref_sine(int'(ph[23:12])) : 0;
      e.req   = req_tag;
      sb.push_back(e);
      if (upd) begin
         m_tune = {m_hi, m_lo}; m_phase = m_ph; m_counted = (m_mode == 2'd2);
         m_left = m_cyc; m_acc = '0;
      end else if (act) begin
         s = {1'b0, m_acc} + {1'b0, m_tune};
         if (m_counted && s[24]) m_left = m_left - 1'b1;
         m_acc = s[23:0];
      end
      if (wr) begin
         case (a)
            3'd0: m_hi = d;
            3'd1: m_lo = d[15:8];
            3'd2: m_ph = d;
            3'd3: m_cyc = d;
            3'd4: m_mode = d[1:0];
            default: ;
         endcase
      end
      @(negedge clk);
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [15:0] d, input logic en);
      cyc(1'b1, a, d, 1'b0, en);
   endtask

   task automatic run(input int n, input logic en);
      for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'h0, 1'b0, en);
   endtask

   task automatic commit(input logic en);
      cyc(1'b0, 3'd0, 16'h0, 1'b1, en);
   endtask

   // monitor: compare each expected item with the output 5 ns after the edge
   always @(posedge clk) begin
      exp_t e;
      int   got, diff;
      #5;
      if (sb.size() > 0) begin
         e    = sb.pop_front();
         got  = int'($signed(sample_o));
         diff = got - e.value;
         n_chk++;
         if (valid_o !== e.valid || diff > 1 || diff < -1) begin
            n_bad++;
            $display("FAIL %s: valid=%0b sample=%0d, expected valid=%0b sample=%0d",
                     e.req, valid_o, got, e.valid, e.value);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state seen directly at the ports
      n_chk++;
      if (valid_o !== 1'b0 || sample_o !== 14'h0) begin
         n_bad++;
         $display("FAIL R1: valid=%0b sample=%0h, expected valid=0 sample=0", valid_o, sample_o);
      end
      req_tag = "R1"; run(4, 1'b1);

      // R3: shadow writes are invisible before commit
      req_tag = "R3";
      wr_reg(3'd0, 16'h0100, 1'b1);
      wr_reg(3'd1, 16'h80FF, 1'b1);
      run(3, 1'b1);
      // R2: odd tuning word with junk in the ignored low byte
      req_tag = "R2"; commit(1'b1); run(20, 1'b1);

      // R3: commit and write together commit the old shadow value
      req_tag = "R3";
      cyc(1'b1, 3'd0, 16'h1000, 1'b1, 1'b1);
      run(6, 1'b1);

      // R7: 1/16-cycle word sweeps all four quadrants
      req_tag = "R7";
      wr_reg(3'd0, 16'h1000, 1'b1); wr_reg(3'd1, 16'h0000, 1'b1);
      commit(1'b1); run(40, 1'b1);

      // R6: zero word, offsets pick fixed table points
      req_tag = "R6";
      wr_reg(3'd0, 16'h0000, 1'b1);
      wr_reg(3'd2, 16'h4000, 1'b1); commit(1'b1); run(3, 1'b1);
      wr_reg(3'd2, 16'hC000, 1'b1); commit(1'b1); run(3, 1'b1);
      wr_reg(3'd2, 16'h2A80, 1'b1); commit(1'b1); run(3, 1'b1);

      // R5: near-full-scale word exercises modulo wrap
      req_tag = "R5";
      wr_reg(3'd2, 16'h0000, 1'b1);
      wr_reg(3'd0, 16'hFFFF, 1'b1); wr_reg(3'd1, 16'hF000, 1'b1);
      commit(1'b1); run(12, 1'b1);

      // R8: enable gaps hold phase and silence the output
      req_tag = "R8";
      wr_reg(3'd0, 16'h0C35, 1'b1); wr_reg(3'd1, 16'h7700, 1'b1);
      commit(1'b1); run(5, 1'b1); run(6, 1'b0); run(5, 1'b1);

      // R9: counted mode, three whole periods of a quarter-cycle word
      req_tag = "R9";
      wr_reg(3'd0, 16'h4000, 1'b1); wr_reg(3'd1, 16'h0000, 1'b1);
      wr_reg(3'd3, 16'd3, 1'b1); wr_reg(3'd4, 16'h0002, 1'b1);
      commit(1'b1); run(20, 1'b1);
      // R4: commit restarts the period count and the phase
      req_tag = "R4"; commit(1'b1); run(16, 1'b1);

      // R10: count of zero in counted mode
      req_tag = "R10";
      wr_reg(3'd3, 16'd0, 1'b1); commit(1'b1); run(8, 1'b1);

      // R9: other mode value runs without limit
      req_tag = "R9";
      wr_reg(3'd3, 16'd1, 1'b1); wr_reg(3'd4, 16'h0001, 1'b1);
      commit(1'b1); run(16, 1'b1);

      // R11: writes to unused addresses change nothing
      req_tag = "R11";
      wr_reg(3'd5, 16'hFFFF, 1'b1); wr_reg(3'd6, 16'h1234, 1'b1);
      wr_reg(3'd7, 16'hABCD, 1'b1);
      commit(1'b1); run(10, 1'b1);

      run(2, 1'b0);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule